// File: doc/BRIEF.md
# Flash Sector Write Guard

This block sits in front of a shared serial flash controller and decides which of two requesters may issue the next flash command. One requester is the host processor. The other is a trusted management processor. The guard forwards one command at a time to the downstream controller. It holds that command until the controller reports completion. When both requesters are waiting, the trusted one is served first.

The flash is split into sixteen equal sectors. The top address bits select the sector. A lock register holds one bit per sector. Bits can only be set. Once set, a bit stays set until the next reset. This lets boot code protect its own verification sectors in one step and the remaining firmware sectors in another, while some sectors stay writable during runtime.

The locks restrict only the host. A host program or erase aimed at a locked sector is refused: it never reaches the controller, the host receives an acknowledge together with an error pulse, and a sticky flag records the address of the first such attempt. Reads from either side, and every command from the trusted side, always go through.

Top module: `flash_sector_guard`

## Requirements
- R1: After reset, all lock bits are 0, the violation flag is 0, and no command is presented downstream or acknowledged.
- R2: A cycle with `lockWe` high ORs `lockSetMask` into the lock bits. A bit can go from 0 to 1 but never back, so writing 0 to a set bit leaves it set. Only reset clears the bits.
- R3: Commands are encoded on 2 bits: 00 read, 01 program, 10 erase, 11 reserved (treated as modifying). A host command with code 01, 10 or 11 that targets a locked sector is never forwarded. Instead, `hostAck` and `hostErr` pulse together for one cycle, in the cycle after the request is taken.
- R4: A host read (code 00) is forwarded whatever the lock state. A host program or erase to an unlocked sector is forwarded with its code and address unchanged and `dnFromTrust` low.
- R5: Every trusted command, including program and erase to locked sectors, is forwarded with `dnFromTrust` high and no error.
- R6: The sector index is the top 4 bits of the address, so all addresses in one sector share one lock bit.
- R7: The first refused host command sets `violFlag` and captures its address in `violAddr`. Both keep their values until reset, and later refusals do not change the captured address.
- R8: If both requesters are pending while the guard is idle, the trusted command is forwarded first.
- R9: `dnValid` and the forwarded command stay stable until `dnDone` is sampled high. No new request preempts the command in flight. The owner's acknowledge then pulses for exactly one cycle in the next cycle, and the two acknowledges are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host request, held until hostAck |
| hostOp | input | 2 | Host command code |
| hostAddr | input | ADDR_W | Host byte address |
| hostAck | output | 1 | Host command finished or refused |
| hostErr | output | 1 | Host command refused (with hostAck) |
| trustReq | input | 1 | Trusted request, held until trustAck |
| trustOp | input | 2 | Trusted command code |
| trustAddr | input | ADDR_W | Trusted byte address |
| trustAck | output | 1 | Trusted command finished |
| lockWe | input | 1 | Lock register write strobe |
| lockSetMask | input | NUM_SECTORS | Bits to set in the lock register |
| lockState | output | NUM_SECTORS | Current lock bits |
| violFlag | output | 1 | Sticky refused-write flag |
| violAddr | output | ADDR_W | Address of the first refused command |
| dnValid | output | 1 | Command presented downstream |
| dnOp | output | 2 | Forwarded command code |
| dnAddr | output | ADDR_W | Forwarded address |
| dnFromTrust | output | 1 | Forwarded command came from the trusted side |
| dnDone | input | 1 | Downstream completion |

## Verification
The bench builds the guard with a 12-bit address and the default sixteen sectors. This gives 256-byte sectors, so random addresses land in every sector and on sector boundaries often. Lock masks are set a little at a time during the random phase. As a result, the same sector is seen both unlocked and locked, and blocked and permitted host commands meet simultaneous trusted requests under both lock states. Downstream latency varies from zero to three extra cycles, which exercises the hold-until-done behaviour.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } flashOp_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUSY = 2'b01,
    ST_ACK  = 2'b10
  } guardState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeTrust;
    logic takeHost;
    logic refuseHost;
  } guardStrobe_t;

endpackage

// File: rtl/fg_ctrl.sv
module fg_ctrl
  import flash_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostReq,
  input  logic         trustReq,
  input  logic         hostBlocked,
  input  logic         dnDone,
  output guardStrobe_t strb,
  output logic         dnValid,
  output logic         hostAck,
  output logic         hostErr,
  output logic         trustAck
);

  guardState_t stateQ, stateD;
  logic ownerTrustQ, ownerTrustD;
  logic errQ, errD;

  always_comb begin
    stateD      = stateQ;
    ownerTrustD = ownerTrustQ;
    errD        = errQ;
    strb        = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (trustReq) begin
          strb.takeTrust = 1'b1;
          ownerTrustD    = 1'b1;
          errD           = 1'b0;
          stateD         = ST_BUSY;
        end else if (hostReq) begin
          ownerTrustD = 1'b0;
          if (hostBlocked) begin
            strb.refuseHost = 1'b1;
            errD            = 1'b1;
            stateD          = ST_ACK;
          end else begin
            strb.takeHost = 1'b1;
            errD          = 1'b0;
            stateD        = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (dnDone) stateD = ST_ACK;
      end
      ST_ACK:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      ownerTrustQ <= 1'b0;
      errQ        <= 1'b0;
    end else begin
      stateQ      <= stateD;
      ownerTrustQ <= ownerTrustD;
      errQ        <= errD;
    end
  end

  assign dnValid  = (stateQ == ST_BUSY);
  assign hostAck  = (stateQ == ST_ACK) && !ownerTrustQ;
  assign trustAck = (stateQ == ST_ACK) && ownerTrustQ;
  assign hostErr  = hostAck && errQ;

  AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(hostAck && trustAck)); // R9
  AST_ERR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    hostErr |-> hostAck); // R3
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && !dnDone) |=> dnValid); // R9
  AST_DONE_ACKS: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && dnDone) |=> ((hostAck || trustAck) && !dnValid)); // R9
  AST_TRUST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && trustReq) |=> (dnValid && ownerTrustQ)); // R8

endmodule

// File: rtl/fg_datapath.sv
module fg_datapath
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_SECTORS = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  guardStrobe_t           strb,
  input  logic [1:0]             hostOp,
  input  logic [ADDR_W-1:0]      hostAddr,
  input  logic [1:0]             trustOp,
  input  logic [ADDR_W-1:0]      trustAddr,
  input  logic                   lockWe,
  input  logic [NUM_SECTORS-1:0] lockSetMask,
  output logic                   hostBlocked,
  output logic [NUM_SECTORS-1:0] lockState,
  output logic                   violFlag,
  output logic [ADDR_W-1:0]      violAddr,
  output logic [1:0]             dnOp,
  output logic [ADDR_W-1:0]      dnAddr,
  output logic                   dnFromTrust
);

  localparam int IDX_W = $clog2(NUM_SECTORS);

  logic [NUM_SECTORS-1:0] lockQ;
  logic [IDX_W-1:0]       hostSector;
  logic                   hostModifies;

  // one set-only bit per sector
  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rstN)                        lockQ[s] <= 1'b0;
      else if (lockWe && lockSetMask[s]) lockQ[s] <= 1'b1;
    end
  end

  assign hostSector   = hostAddr[ADDR_W-1 -: IDX_W];
  assign hostModifies = (hostOp != OP_READ);
  assign hostBlocked  = hostModifies && lockQ[hostSector];
  assign lockState    = lockQ;

  // command register toward downstream
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dnOp        <= OP_READ;
      dnAddr      <= '0;
      dnFromTrust <= 1'b0;
    end else if (strb.takeTrust) begin
      dnOp        <= trustOp;
      dnAddr      <= trustAddr;
      dnFromTrust <= 1'b1;
    end else if (strb.takeHost) begin
      dnOp        <= hostOp;
      dnAddr      <= hostAddr;
      dnFromTrust <= 1'b0;
    end
  end

  // first refused address, sticky
  always_ff @(posedge clk) begin
    if (!rstN) begin
      violFlag <= 1'b0;
      violAddr <= '0;
    end else if (strb.refuseHost && !violFlag) begin
      violFlag <= 1'b1;
      violAddr <= hostAddr;
    end
  end

  AST_LOCK_SET_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lockQ) & ~lockQ) == '0); // R2
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(violFlag) |-> (violFlag && $stable(violAddr))); // R7
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.takeTrust, strb.takeHost, strb.refuseHost})); // R9

endmodule

// File: rtl/flash_sector_guard.sv
module flash_sector_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_SECTORS = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostReq,
  input  logic [1:0]             hostOp,
  input  logic [ADDR_W-1:0]      hostAddr,
  output logic                   hostAck,
  output logic                   hostErr,
  input  logic                   trustReq,
  input  logic [1:0]             trustOp,
  input  logic [ADDR_W-1:0]      trustAddr,
  output logic                   trustAck,
  input  logic                   lockWe,
  input  logic [NUM_SECTORS-1:0] lockSetMask,
  output logic [NUM_SECTORS-1:0] lockState,
  output logic                   violFlag,
  output logic [ADDR_W-1:0]      violAddr,
  output logic                   dnValid,
  output logic [1:0]             dnOp,
  output logic [ADDR_W-1:0]      dnAddr,
  output logic                   dnFromTrust,
  input  logic                   dnDone
);

  localparam int IDX_W = $clog2(NUM_SECTORS);

  guardStrobe_t strb;
  logic         hostBlocked;
  logic [IDX_W-1:0] dnSector;

  fg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostReq     (hostReq),
    .trustReq    (trustReq),
    .hostBlocked (hostBlocked),
    .dnDone      (dnDone),
    .strb        (strb),
    .dnValid     (dnValid),
    .hostAck     (hostAck),
    .hostErr     (hostErr),
    .trustAck    (trustAck)
  );

  fg_datapath #(
    .ADDR_W      (ADDR_W),
    .NUM_SECTORS (NUM_SECTORS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .hostOp      (hostOp),
    .hostAddr    (hostAddr),
    .trustOp     (trustOp),
    .trustAddr   (trustAddr),
    .lockWe      (lockWe),
    .lockSetMask (lockSetMask),
    .hostBlocked (hostBlocked),
    .lockState   (lockState),
    .violFlag    (violFlag),
    .violAddr    (violAddr),
    .dnOp        (dnOp),
    .dnAddr      (dnAddr),
    .dnFromTrust (dnFromTrust)
  );

  assign dnSector = dnAddr[ADDR_W-1 -: IDX_W];

  AST_NO_LOCKED_HOST_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dnValid) && !dnFromTrust && dnOp != OP_READ)
      |-> (($past(lockState) & (NUM_SECTORS'(1) << dnSector)) == '0)); // R3
  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && !dnDone) |=> ($stable(dnAddr) && $stable(dnOp) && $stable(dnFromTrust))); // R9

endmodule

// File: tb/flash_sector_guard_tb_top.sv
module flash_sector_guard_tb_top;
  localparam int AW = 12;
  localparam int NS = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic hostReq = 1'b0, trustReq = 1'b0, lockWe = 1'b0, dnDone = 1'b0;
  logic [1:0] hostOp = '0, trustOp = '0;
  logic [AW-1:0] hostAddr = '0, trustAddr = '0;
  logic [NS-1:0] lockSetMask = '0;
  logic hostAck, hostErr, trustAck, violFlag, dnValid, dnFromTrust;
  logic [NS-1:0] lockState;
  logic [AW-1:0] violAddr, dnAddr;
  logic [1:0] dnOp;

  flash_sector_guard #(.ADDR_W(AW), .NUM_SECTORS(NS)) dut_i (
    .clk(clk), .rstN(rstN),
    .hostReq(hostReq), .hostOp(hostOp), .hostAddr(hostAddr),
    .hostAck(hostAck), .hostErr(hostErr),
    .trustReq(trustReq), .trustOp(trustOp), .trustAddr(trustAddr),
    .trustAck(trustAck),
    .lockWe(lockWe), .lockSetMask(lockSetMask), .lockState(lockState),
    .violFlag(violFlag), .violAddr(violAddr),
    .dnValid(dnValid), .dnOp(dnOp), .dnAddr(dnAddr),
    .dnFromTrust(dnFromTrust), .dnDone(dnDone)
  );

  int errors = 0;
  int checks = 0;
  logic [NS-1:0] expLock = '0;
  logic expViol = 1'b0;
  logic [AW-1:0] expViolAddr = '0;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit expBlocked(logic [1:0] op, logic [AW-1:0] a);
    return (op != 2'b00) && expLock[a[AW-1 -: IW]];
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    hostReq = 0; trustReq = 0; lockWe = 0; dnDone = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expLock = '0; expViol = 0; expViolAddr = '0;
    @(negedge clk);
    check("R1", "lockState", lockState, 0);
    check("R1", "violFlag", violFlag, 0);
    check("R1", "dnValid/acks", {dnValid, hostAck, trustAck}, 0);
  endtask

  task automatic setLock(logic [NS-1:0] mask);
    @(negedge clk); lockWe = 1'b1; lockSetMask = mask;
    @(negedge clk); lockWe = 1'b0;
    expLock = expLock | mask;
    check("R2", "lockState", lockState, expLock);
  endtask

  task automatic runPair(bit hEn, logic [1:0] hOp, logic [AW-1:0] hA,
                         bit tEn, logic [1:0] tOp, logic [AW-1:0] tA);
    bit hBlk = hEn && expBlocked(hOp, hA);
    bit hDone = !hEn, tDone = !tEn, hSawErr = 0, inCmd = 0, firstTrust = 0;
    bit stableOk = 1;
    int fwd = 0, waitCnt = 0;
    int lat = $urandom_range(0, 3);
    logic [AW-1:0] curAddr = '0;
    @(negedge clk);
    hostReq = hEn; hostOp = hOp; hostAddr = hA;
    trustReq = tEn; trustOp = tOp; trustAddr = tA;
    for (int cyc = 0; cyc < 60 && !(hDone && tDone); cyc++) begin
      @(negedge clk);
      if (dnDone) dnDone = 1'b0;
      if (hostAck) begin hDone = 1; hSawErr = hostErr; hostReq = 0; end
      if (trustAck) begin tDone = 1; trustReq = 0; end
      if (dnValid && !inCmd && waitCnt == 0) begin
        inCmd = 1; curAddr = dnAddr;
        if (fwd == 0) firstTrust = dnFromTrust;
        fwd++;
        if (dnFromTrust)
          check("R5", "trusted fields", {dnOp, dnAddr}, {tOp, tA});
        else
          check("R4", "host fields", {dnOp, dnAddr}, {hOp, hA});
      end
      if (inCmd) begin
        if (!dnValid || dnAddr != curAddr) stableOk = 0;
        if (waitCnt == lat) begin dnDone = 1'b1; inCmd = 0; waitCnt = 0; end
        else waitCnt++;
      end
    end
    check("R9", "both acknowledged", hDone && tDone, 1);
    check("R9", "held stable", stableOk, 1);
    check("R3", "forward count", fwd, int'(tEn) + int'(hEn && !hBlk));
    if (hEn) check("R3", "hostErr", hSawErr, hBlk);
    if (hEn && tEn && !hBlk) check("R8", "trusted first", firstTrust, 1);
    if (hBlk && !expViol) begin expViol = 1; expViolAddr = hA; end
    check("R7", "violFlag", violFlag, expViol);
    check("R7", "violAddr", expViol ? violAddr : '0, expViolAddr);
    hostReq = 0; trustReq = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    doReset();
    // R4: unlocked writes and reads pass
    runPair(1, 2'b01, 12'h5FF, 0, 2'b00, '0);
    // R2: verification sectors first, then others
    setLock(16'h0003);
    setLock(16'h0020);
    setLock(16'h0000); // R2 no clear
    // R6: sector 5 boundary
    runPair(1, 2'b01, 12'h5FF, 0, 2'b00, '0); // blocked, first violation
    runPair(1, 2'b10, 12'h500, 0, 2'b00, '0); // erase blocked, R7 keep first
    runPair(1, 2'b11, 12'h000, 0, 2'b00, '0); // reserved blocked R3
    runPair(1, 2'b01, 12'h600, 0, 2'b00, '0); // R6 sector 6 free
    runPair(1, 2'b01, 12'h4FF, 0, 2'b00, '0); // R6 sector 4 free
    runPair(1, 2'b00, 12'h5A0, 0, 2'b00, '0); // R4 read locked
    runPair(0, 2'b00, '0, 1, 2'b10, 12'h100); // R5 trusted erase locked
    runPair(1, 2'b01, 12'h700, 1, 2'b01, 12'h5FF); // R8
    runPair(1, 2'b01, 12'h1F0, 1, 2'b00, 12'h800); // blocked host plus trust
    for (int i = 0; i < 80; i++) begin
      if ($urandom_range(0, 9) == 0) setLock(NS'(1) << $urandom_range(0, NS-1));
      runPair($urandom_range(0, 3) != 0, 2'($urandom), 12'($urandom),
              $urandom_range(0, 2) == 0, 2'($urandom), 12'($urandom));
    end
    // R1: only reset clears locks and flag
    doReset();
    runPair(1, 2'b01, 12'h5FF, 0, 2'b00, '0);
    summary();
  end

endmodule